// File: doc/BRIEF.md
# Delay Line Phase Programming Sequencer

This block owns the 32-bit configuration word of a tunable receive-clock delay line. It also reads back a status word from that line. It runs one of two commands at a time.

- **Init** puts the line through reset and power-down. It places the current card clock rate into a 3-bit frequency bin, re-enables the line with its clock output, and then waits for lock.
- **Set-phase** selects one of sixteen sampling phases. The output enable is dropped before the phase field is rewritten and raised again afterwards. The phase is written in its reflected binary (gray) form. The clock-data-recovery enable is turned back on only after the output is confirmed running.

Every wait on the line is a bounded poll. The poll reads the status every `POLL_TICKS` cycles, which is one microsecond at the intended clock. It gives up after `POLL_MAX` reads and reports a timeout.

A local model of the delay line sits inside the block. It mirrors the output-enable bit and raises lock a configurable number of cycles after the line is made ready. A hold input freezes the model so that a stuck line can be represented. Every change to the configuration and vendor words is a read-modify-write, so bits that a step does not name keep their value.

Top module: `dps_top`

## Requirements
- R1: After reset, `cfgWord` equals `CFG_RESET`, `vendWord` equals `VEND_RESET`, `statWord` is zero, and `busy`, `done` and `timedOut` are low.
- R2: A successful init ends with the following state:
  - `vendWord` bit 1 (power save) is clear;
  - `cfgWord` bit 30 (line reset) and bit 29 (power-down) are clear;
  - bit 16 (line enable) and bit 18 (clock output enable) are set;
  - `statWord` bit 7 (lock) is set;
  - `timedOut` is low while `done` is high.
- R3: Init writes a frequency bin to `cfgWord[26:24]` from `freqMhz`:
  - 0 for rates up to 112;
  - 1 to 7 for rates up to 125, 137, 150, 162, 175, 187 and 200, taking the first limit that is not exceeded;
  - 0 for rates above 200.
- R4: A successful set-phase with phase p leaves the following state:
  - `cfgWord[23:20]` equals p XOR (p>>1);
  - bit 17 (CDR enable), bit 16 and bit 18 are set;
  - bit 19 (external phase select) is clear.
- R5: The phase field changes only while the clock output enable is clear in `cfgWord` and its readback in `statWord` bit 18 has already been seen at 0.
- R6: Each poll reads the status every `POLL_TICKS` cycles, starting on entry. A timeout is reported on the `POLL_MAX`-th failed read. Busy then lasts (`POLL_MAX`-1)*`POLL_TICKS`+10 cycles for init and (`POLL_MAX`-1)*`POLL_TICKS`+3 cycles for a set-phase that stalls at its first wait. The configuration is left at the step reached.
- R7: A command is taken only when idle. `busy` stays high from the cycle after acceptance through the single cycle in which `done` pulses. A `cmdValid` seen while busy is ignored.
- R8: Configuration bits outside 16..26, 29 and 30 never leave their reset value. Only bit 1 of the vendor word ever changes. Set-phase leaves the frequency bin unchanged.
- R9: CDR enable is raised only when the clock output enable is set and `statWord` bit 18 reads back 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request, taken when idle |
| cmdInit | input | 1 | 1 selects init, 0 selects set-phase |
| cmdPhase | input | 4 | Phase for set-phase |
| freqMhz | input | FREQ_W | Card clock rate in MHz, used by init |
| respHold | input | 1 | Freezes the delay-line model's responses |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | Completion status, 1 when a poll expired |
| cfgWord | output | 32 | Delay-line configuration word |
| vendWord | output | 32 | Vendor control word (bit 1 power save) |
| statWord | output | 32 | Status: bit 7 lock, bit 18 output-enable readback |

## Verification
The hardest states to reach are the two expired polls. They need the line to stay unresponsive for a full poll window at a precise point in the sequence. The bench holds `respHold` high before issuing a command.

- For init, the hold makes the lock wait expire.
- For set-phase, the command is issued right after a good phase, while the output readback is still 1, so the wait for it to fall expires.

In both cases the exact busy length is compared with the arithmetic window. Near-exhaustive sweeps cover every phase and every frequency from 0 to 215 plus the top of the input range.

// File: rtl/dps_pkg.sv
package dps_pkg;

  localparam int EN_BIT    = 16;
  localparam int CDR_BIT   = 17;
  localparam int OE_BIT    = 18;
  localparam int EXT_BIT   = 19;
  localparam int PDN_BIT   = 29;
  localparam int RST_BIT   = 30;
  localparam int LOCK_BIT  = 7;
  localparam int PS_BIT    = 1;
  localparam int PH_LO     = 20;
  localparam int BIN_LO    = 24;
  localparam int NUM_LIMS  = 7;
  localparam int BIN_FLOOR = 112;
  localparam int BIN_LIM [NUM_LIMS] = '{125, 137, 150, 162, 175, 187, 200};

  typedef enum logic [1:0] {
    WAIT_OE_LOW,
    WAIT_OE_HIGH,
    WAIT_LOCK
  } pollSel_e;

  typedef struct packed {
    logic        latch;
    logic        cfgWr;
    logic [31:0] setMask;
    logic [31:0] clrMask;
    logic        phaseWr;
    logic        binWr;
    logic        pwrSaveClr;
    logic        pollEn;
    pollSel_e    pollSel;
  } strobe_t;

  function automatic logic [31:0] bitMask(input int pos);
    return 32'(1) << pos;
  endfunction

  function automatic logic [3:0] toGray(input logic [3:0] p);
    return p ^ (p >> 1);
  endfunction

  function automatic logic [2:0] freqBin(input int unsigned f);
    logic [2:0] b;
    logic hit;
    b = 3'd0;
    hit = (f <= BIN_FLOOR);
    for (int i = 0; i < NUM_LIMS; i++) begin
      if (!hit && f <= BIN_LIM[i]) begin
        b = 3'(i + 1);
        hit = 1'b1;
      end
    end
    return b;
  endfunction

endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    cmdInit,
  input  logic    pollOk,
  input  logic    pollTo,
  output strobe_t strb,
  output logic    busy,
  output logic    done,
  output logic    timedOut
);

  typedef enum logic [4:0] {
    ST_IDLE, ST_I_PWRS, ST_I_RST, ST_I_PDN, ST_I_BIN, ST_I_UNRST, ST_I_UNPDN,
    ST_I_EN, ST_I_OE, ST_I_LOCK, ST_P_PREP, ST_P_WAIT0, ST_P_FIELD,
    ST_P_OEON, ST_P_WAIT1, ST_P_CDR, ST_DONE
  } state_e;

  state_e state, nextState;
  logic   toNext;

  always_comb begin
    nextState = state;
    strb      = '0;
    toNext    = 1'b0;
    unique case (state)
      ST_IDLE: if (cmdValid) begin
        strb.latch = 1'b1;
        nextState  = cmdInit ? ST_I_PWRS : ST_P_PREP;
      end
      ST_I_PWRS:  begin strb.pwrSaveClr = 1'b1; nextState = ST_I_RST; end
      ST_I_RST:   begin strb.cfgWr = 1'b1; strb.setMask = bitMask(RST_BIT); nextState = ST_I_PDN; end
      ST_I_PDN:   begin strb.cfgWr = 1'b1; strb.setMask = bitMask(PDN_BIT); nextState = ST_I_BIN; end
      ST_I_BIN:   begin strb.binWr = 1'b1; nextState = ST_I_UNRST; end
      ST_I_UNRST: begin strb.cfgWr = 1'b1; strb.clrMask = bitMask(RST_BIT); nextState = ST_I_UNPDN; end
      ST_I_UNPDN: begin strb.cfgWr = 1'b1; strb.clrMask = bitMask(PDN_BIT); nextState = ST_I_EN; end
      ST_I_EN:    begin strb.cfgWr = 1'b1; strb.setMask = bitMask(EN_BIT); nextState = ST_I_OE; end
      ST_I_OE:    begin strb.cfgWr = 1'b1; strb.setMask = bitMask(OE_BIT); nextState = ST_I_LOCK; end
      ST_I_LOCK: begin
        strb.pollEn = 1'b1; strb.pollSel = WAIT_LOCK;
        if (pollOk || pollTo) nextState = ST_DONE;
      end
      ST_P_PREP: begin
        strb.cfgWr   = 1'b1;
        strb.clrMask = bitMask(CDR_BIT) | bitMask(OE_BIT);
        strb.setMask = bitMask(EXT_BIT) | bitMask(EN_BIT);
        nextState    = ST_P_WAIT0;
      end
      ST_P_WAIT0: begin
        strb.pollEn = 1'b1; strb.pollSel = WAIT_OE_LOW;
        if (pollOk) nextState = ST_P_FIELD;
        else if (pollTo) nextState = ST_DONE;
      end
      ST_P_FIELD: begin strb.phaseWr = 1'b1; nextState = ST_P_OEON; end
      ST_P_OEON:  begin strb.cfgWr = 1'b1; strb.setMask = bitMask(OE_BIT); nextState = ST_P_WAIT1; end
      ST_P_WAIT1: begin
        strb.pollEn = 1'b1; strb.pollSel = WAIT_OE_HIGH;
        if (pollOk) nextState = ST_P_CDR;
        else if (pollTo) nextState = ST_DONE;
      end
      ST_P_CDR: begin
        strb.cfgWr   = 1'b1;
        strb.setMask = bitMask(CDR_BIT);
        strb.clrMask = bitMask(EXT_BIT);
        nextState    = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
    toNext = strb.pollEn && pollTo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timedOut <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.latch) timedOut <= 1'b0;
      else if (toNext) timedOut <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int          FREQ_W     = 10,
  parameter int          POLL_TICKS = 250,
  parameter int          POLL_MAX   = 50,
  parameter logic [31:0] CFG_RESET  = 32'h8000_0001,
  parameter logic [31:0] VEND_RESET = 32'h0000_0013
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [3:0]        cmdPhase,
  input  logic [FREQ_W-1:0] freqMhz,
  input  logic [31:0]       statWord,
  output logic [31:0]       cfgWord,
  output logic [31:0]       vendWord,
  output logic              pollOk,
  output logic              pollTo
);

  localparam int TICK_W = $clog2(POLL_TICKS + 1);
  localparam int TRY_W  = $clog2(POLL_MAX + 1);

  logic [31:0]       cfgQ, vendQ;
  logic [3:0]        phaseQ;
  logic [2:0]        binQ;
  logic [TICK_W-1:0] tickCnt;
  logic [TRY_W-1:0]  tryCnt;
  logic              readNow, match;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= CFG_RESET;
      vendQ  <= VEND_RESET;
      phaseQ <= '0;
      binQ   <= '0;
    end else begin
      if (strb.latch) begin
        phaseQ <= cmdPhase;
        binQ   <= freqBin(32'(freqMhz));
      end
      if (strb.cfgWr) cfgQ <= (cfgQ & ~strb.clrMask) | strb.setMask;
      else if (strb.phaseWr) cfgQ[PH_LO +: 4] <= toGray(phaseQ);
      else if (strb.binWr) cfgQ[BIN_LO +: 3] <= binQ;
      if (strb.pwrSaveClr) vendQ[PS_BIT] <= 1'b0;
    end
  end

  always_comb begin
    unique case (strb.pollSel)
      WAIT_OE_LOW:  match = !statWord[OE_BIT];
      WAIT_OE_HIGH: match = statWord[OE_BIT];
      WAIT_LOCK:    match = statWord[LOCK_BIT];
      default:      match = 1'b0;
    endcase
  end

  assign readNow = strb.pollEn && (tickCnt == '0);
  assign pollOk  = readNow && match;
  assign pollTo  = readNow && !match && (tryCnt == TRY_W'(POLL_MAX - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      tryCnt  <= '0;
    end else if (!strb.pollEn) begin
      tickCnt <= '0;
      tryCnt  <= '0;
    end else begin
      if (readNow && !match) tryCnt <= tryCnt + 1'b1;
      tickCnt <= (tickCnt == TICK_W'(POLL_TICKS - 1)) ? '0 : tickCnt + 1'b1;
    end
  end

  assign cfgWord  = cfgQ;
  assign vendWord = vendQ;

endmodule

// File: rtl/dps_line_model.sv
module dps_line_model
  import dps_pkg::*;
#(
  parameter int RESP_DLY = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cfgWord,
  input  logic        respHold,
  output logic [31:0] statWord
);

  localparam int CNT_W = $clog2(RESP_DLY + 1);

  logic             oeSeen, lockQ, lockReady;
  logic [CNT_W-1:0] oeCnt, lockCnt;

  assign lockReady = cfgWord[EN_BIT] && cfgWord[OE_BIT] &&
                     !cfgWord[PDN_BIT] && !cfgWord[RST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeSeen <= 1'b0;
      oeCnt  <= '0;
    end else if (cfgWord[OE_BIT] == oeSeen || respHold) begin
      oeCnt <= '0;
    end else if (oeCnt == CNT_W'(RESP_DLY - 1)) begin
      oeSeen <= cfgWord[OE_BIT];
      oeCnt  <= '0;
    end else begin
      oeCnt <= oeCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ   <= 1'b0;
      lockCnt <= '0;
    end else if (!lockReady) begin
      lockQ   <= 1'b0;
      lockCnt <= '0;
    end else if (!lockQ && !respHold) begin
      if (lockCnt == CNT_W'(RESP_DLY - 1)) lockQ <= 1'b1;
      else lockCnt <= lockCnt + 1'b1;
    end
  end

  always_comb begin
    statWord           = '0;
    statWord[LOCK_BIT] = lockQ;
    statWord[OE_BIT]   = oeSeen;
  end

endmodule

// File: rtl/dps_top.sv
module dps_top #(
  parameter int          FREQ_W     = 10,
  parameter int          POLL_TICKS = 250,
  parameter int          POLL_MAX   = 50,
  parameter int          RESP_DLY   = 20,
  parameter logic [31:0] CFG_RESET  = 32'h8000_0001,
  parameter logic [31:0] VEND_RESET = 32'h0000_0013
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdInit,
  input  logic [3:0]        cmdPhase,
  input  logic [FREQ_W-1:0] freqMhz,
  input  logic              respHold,
  output logic              busy,
  output logic              done,
  output logic              timedOut,
  output logic [31:0]       cfgWord,
  output logic [31:0]       vendWord,
  output logic [31:0]       statWord
);

  dps_pkg::strobe_t strb;
  logic pollOk, pollTo;

  dps_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdInit(cmdInit),
    .pollOk(pollOk), .pollTo(pollTo), .strb(strb),
    .busy(busy), .done(done), .timedOut(timedOut)
  );

  dps_datapath #(
    .FREQ_W(FREQ_W), .POLL_TICKS(POLL_TICKS), .POLL_MAX(POLL_MAX),
    .CFG_RESET(CFG_RESET), .VEND_RESET(VEND_RESET)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdPhase(cmdPhase),
    .freqMhz(freqMhz), .statWord(statWord), .cfgWord(cfgWord),
    .vendWord(vendWord), .pollOk(pollOk), .pollTo(pollTo)
  );

  dps_line_model #(.RESP_DLY(RESP_DLY)) i_model (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .respHold(respHold),
    .statWord(statWord)
  );

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter logic [31:0] CFG_RESET  = 32'h8000_0001,
  parameter logic [31:0] VEND_RESET = 32'h0000_0013
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic [31:0] cfgWord,
  input logic [31:0] vendWord,
  input logic [31:0] statWord
);

  localparam logic [31:0] FREE_MASK = 32'h9800_FFFF;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R7
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);  // R7
  AST_PHASE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgWord[23:20]) |-> $past(!cfgWord[18] && !statWord[18]));  // R5
  AST_CDR_AFTER_OE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgWord[17]) |-> (cfgWord[18] && statWord[18]));  // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(cfgWord));  // R8
  AST_FREE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord & FREE_MASK) == (CFG_RESET & FREE_MASK));  // R8
  AST_VEND_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (vendWord | 32'h2) == (VEND_RESET | 32'h2));  // R8

endmodule

bind dps_top dps_checker #(.CFG_RESET(CFG_RESET), .VEND_RESET(VEND_RESET)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .cfgWord(cfgWord), .vendWord(vendWord), .statWord(statWord)
);

// File: tb/test_dps_top.sv
module test_dps_top;

  localparam int          TICKS  = 2;
  localparam int          PMAX   = 50;
  localparam int          DLY    = 3;
  localparam logic [31:0] CFG_RV = 32'h8000_0001;
  localparam logic [31:0] VND_RV = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdInit = 1'b0, respHold = 1'b0;
  logic [3:0]  cmdPhase = '0;
  logic [9:0]  freqMhz = '0;
  logic        busy, done, timedOut;
  logic [31:0] cfgWord, vendWord, statWord;

  int nChecks = 0;
  int nErrs   = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  dps_top #(
    .FREQ_W(10), .POLL_TICKS(TICKS), .POLL_MAX(PMAX), .RESP_DLY(DLY),
    .CFG_RESET(CFG_RV), .VEND_RESET(VND_RV)
  ) i_dps_top (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdInit(cmdInit),
    .cmdPhase(cmdPhase), .freqMhz(freqMhz), .respHold(respHold),
    .busy(busy), .done(done), .timedOut(timedOut),
    .cfgWord(cfgWord), .vendWord(vendWord), .statWord(statWord)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expBin(input int f);
    if (f <= 112) return 0;
    else if (f <= 125) return 1;
    else if (f <= 137) return 2;
    else if (f <= 150) return 3;
    else if (f <= 162) return 4;
    else if (f <= 175) return 5;
    else if (f <= 187) return 6;
    else if (f <= 200) return 7;
    return 0;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nErrs++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      finishRun();
    end
  end

  task automatic doCmd(input logic isInit, input logic [3:0] ph, input int f,
                       input int injAt, input logic [3:0] injPh, output int nBusy);
    @(negedge clk);
    cmdValid = 1'b1; cmdInit = isInit; cmdPhase = ph; freqMhz = 10'(f);
    @(negedge clk);
    cmdValid = 1'b0;
    nBusy = 0;
    for (int k = 0; k < 5000; k++) begin
      if (busy) nBusy++;
      if (done) return;
      if (k == injAt) begin
        cmdValid = 1'b1; cmdInit = 1'b0; cmdPhase = injPh;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
    end
    check("R7 done never seen", 0, 1);
  endtask

  initial begin
    int nb;
    int lastBin;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cfgWord", cfgWord, CFG_RV);
    check("R1 vendWord", vendWord, VND_RV);
    check("R1 statWord", statWord, 0);
    check("R1 busy/done/timedOut", {busy, done, timedOut}, 0);
    rstN = 1'b1;

    // R2 R3 frequency sweep through init
    for (int f = 0; f < 218; f++) begin
      int fr;
      fr = (f < 216) ? f : ((f == 216) ? 511 : 1023);
      doCmd(1'b1, 4'd0, fr, -1, 4'd0, nb);
      check("R2 init ok", timedOut, 0);
      check("R2 lock/oe/en/pdn/rst", {statWord[7], cfgWord[30], cfgWord[29], cfgWord[18], cfgWord[16]}, 5'b10011);
      check("R2 power save cleared", vendWord, VND_RV & ~32'h2);
      check("R3 frequency bin", cfgWord[26:24], expBin(fr));
      check("R8 free cfg bits", cfgWord & 32'h9800_FFFF, CFG_RV & 32'h9800_FFFF);
    end
    lastBin = expBin(1023);

    // R4 R8 R9 phase sweep, ascending then descending
    for (int j = 0; j < 32; j++) begin
      int p;
      p = (j < 16) ? j : 31 - j;
      doCmd(1'b0, 4'(p), 0, -1, 4'd0, nb);
      check("R4 set-phase ok", timedOut, 0);
      check("R4 gray phase field", cfgWord[23:20], p ^ (p >> 1));
      check("R4 ext/oe/cdr/en", {cfgWord[19], cfgWord[18], cfgWord[17], cfgWord[16]}, 4'b0111);
      check("R9 oe readback high", statWord[18], 1);
      check("R8 bin kept by set-phase", cfgWord[26:24], lastBin);
    end

    // R7 command while busy is ignored
    doCmd(1'b0, 4'd9, 0, 2, 4'd4, nb);
    check("R7 field from first command", cfgWord[23:20], 4'd9 ^ 4'd4);
    doCmd(1'b0, 4'd6, 0, 5, 4'd11, nb);
    check("R7 field from first command", cfgWord[23:20], 4'd6 ^ 4'd3);
    check("R7 busy length ok", timedOut, 0);

    // R6 set-phase stalls waiting for output enable to fall
    @(negedge clk);
    respHold = 1'b1;
    doCmd(1'b0, 4'd12, 0, -1, 4'd0, nb);
    check("R6 set-phase timeout flag", timedOut, 1);
    check("R6 set-phase busy cycles", nb, (PMAX - 1) * TICKS + 3);
    check("R6 field untouched on abort", cfgWord[23:20], 4'd6 ^ 4'd3);
    check("R6 ext set, cdr clear on abort", {cfgWord[19], cfgWord[17]}, 2'b10);

    // R6 init stalls waiting for lock
    doCmd(1'b1, 4'd0, 150, -1, 4'd0, nb);
    check("R6 init timeout flag", timedOut, 1);
    check("R6 init busy cycles", nb, (PMAX - 1) * TICKS + 10);
    check("R6 no lock", statWord[7], 0);
    respHold = 1'b0;

    // recovery after timeouts
    doCmd(1'b1, 4'd0, 180, -1, 4'd0, nb);
    check("R2 init recovers", {timedOut, statWord[7]}, 2'b01);
    check("R3 bin after recovery", cfgWord[26:24], expBin(180));
    doCmd(1'b0, 4'd15, 0, -1, 4'd0, nb);
    check("R4 phase after recovery", cfgWord[23:20], 4'd15 ^ 4'd7);
    @(negedge clk);
    check("R7 idle after done", {busy, done}, 0);
    finishRun();
  end

endmodule